// File: doc/BRIEF.md
# Audio Serial Clock Source Generator

This block produces the serial bit clock and the word-select (channel) clock for the output of an audio decoder. A fast system clock samples up to three reference clocks: a sample-rate-related clock, a 12.288/24.576 MHz master clock and a fixed 22.5792 MHz clock. It picks one of them according to the mode pins and the sample-rate code found in the coded stream. It then divides the chosen reference so that the bit clock runs at 64 times the sample rate. The word-select clock marks 32-bit channel slots and starts on the left channel.

In the follower configurations the sample-rate clock is the only source, and its oversampling ratio (256x or 384x) sets the divider. In the automatic configuration the block uses the fixed 22.5792 MHz clock for the 44.1 kHz family. For 48 kHz and 32 kHz it uses the 24.576 MHz master clock. Every change of source waits for the end of a channel slot, parks both outputs low for one system cycle and then restarts. Flag combinations that no configuration allows are reported on an error output, and the generator is held idle while they are present.

Top module: `aclk_source_gen`

## Requirements
- R1: During and right after reset, sck_o and ws_o are 0, src_sel_o is 00 (no source) and config_error_o is 0.
- R2: With mode_sel 10 or 11, or with mode_sel 00 and mst_src_sel 1, the source is the sample-rate clock (src_sel_o = 01). Activity on the master and fixed clock inputs has no effect on sck_o or ws_o.
- R3: For the sample-rate clock, sck_o toggles every 2 of its rising edges when ratio384 is 0 (divide by 4) and every 3 when it is 1 (divide by 6).
- R4: With mode_sel 00 and mst_src_sel 0, rate_code 00 (44.1 kHz) selects the fixed clock (src_sel_o = 11, divide by 8). Rate_code 01 (48 kHz) selects the master clock (src_sel_o = 10, divide by 8). Rate_code 10 (32 kHz) selects the master clock with divide by 12.
- R5: ws_o changes only in the cycle where sck_o falls. It toggles after every 32 falling edges of sck_o and is 0 (left) at the start of each run.
- R6: config_error_o is 1 one cycle after any of these: mode_sel 01; or the automatic configuration with ratio384 = 1, with mclk24 = 0 or with rate_code 11. While such a setting is present, no source is started.
- R7: When the requested source or divider differs from the running one, the change happens only at a word-select boundary (the 32nd sck_o fall). In that cycle src_sel_o becomes 00 and both clocks are 0. The new source starts one cycle later with fresh counters. From the idle state, a valid request starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all reference clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsclk_in | input | 1 | Sample-rate-related reference clock (256x or 384x) |
| mclk_in | input | 1 | Master clock, 12.288 or 24.576 MHz |
| x22_in | input | 1 | Fixed 22.5792 MHz reference |
| mode_sel | input | 2 | Input mode: 00 master, 10/11 slave, 01 illegal |
| mst_src_sel | input | 1 | In master mode: 0 automatic, 1 follow sample-rate clock |
| ratio384 | input | 1 | Sample-rate clock is 384x (1) or 256x (0) |
| mclk24 | input | 1 | Master clock is 24.576 MHz (1) or 12.288 MHz (0) |
| rate_code | input | 2 | Stream sample rate: 00 44.1k, 01 48k, 10 32k, 11 reserved |
| src_sel_o | output | 2 | Active source: 00 none, 01 sample-rate, 10 master, 11 fixed |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, 0 = left channel |
| config_error_o | output | 1 | Illegal configuration flag |

## Verification
A divider count that is off by one shows within one bit-clock period as an sck_o edge landing a reference edge early or late. A wrong slot count shows within one channel slot (32 bit clocks) as a ws_o toggle at the wrong fall. A wrong choice of source or divider is visible on src_sel_o one cycle after the request is taken, and on sck_o within the first bit period. A switch that ignores the slot boundary shows as src_sel_o dropping to 00 at a cycle where sck_o did not just fall. The bench model predicts all four outputs every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FS   = 2'd1,
    SRC_MCLK = 2'd2,
    SRC_X22  = 2'd3
  } src_t;

  localparam int HALF_W = 3;
  localparam int NREF   = 3;

  // Reference rising edges per half bit-clock period, for SCK = 64 x fs.
  function automatic logic [HALF_W-1:0] ref_half(src_t s, logic r384, logic [1:0] rate);
    case (s)
      SRC_FS:   return r384 ? HALF_W'(3) : HALF_W'(2);
      SRC_X22:  return HALF_W'(4);
      SRC_MCLK: return (rate == 2'b10) ? HALF_W'(6) : HALF_W'(4);
      default:  return HALF_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/aclk_edge_sync.sv
module aclk_edge_sync #(
  parameter int NREF   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] ref_in,
  output logic [NREF-1:0] rise_o
);
  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic [STAGES:0] shr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shr <= '0;
      else        shr <= {shr[STAGES-1:0], ref_in[g]};
    end
    assign rise_o[g] = shr[STAGES-1] & ~shr[STAGES];
  end
endmodule

// File: rtl/aclk_src_select.sv
module aclk_src_select
  import aclk_pkg::*;
(
  input  logic [1:0]        mode_sel,
  input  logic              mst_src_sel,
  input  logic              ratio384,
  input  logic              mclk24,
  input  logic [1:0]        rate_code,
  output src_t              req_src,
  output logic [HALF_W-1:0] req_half,
  output logic              cfg_bad
);
  logic auto_mode, follow_fs;

  always_comb begin
    auto_mode = (mode_sel == 2'b00) && !mst_src_sel;
    follow_fs = mode_sel[1] || ((mode_sel == 2'b00) && mst_src_sel);
    cfg_bad   = (mode_sel == 2'b01) ||
                (auto_mode && (ratio384 || !mclk24 || (rate_code == 2'b11)));
    if (cfg_bad)                 req_src = SRC_NONE;
    else if (follow_fs)          req_src = SRC_FS;
    else if (rate_code == 2'b00) req_src = SRC_X22;
    else                         req_src = SRC_MCLK;
    req_half = ref_half(req_src, ratio384, rate_code);
  end
endmodule

// File: rtl/aclk_divider.sv
module aclk_divider
  import aclk_pkg::*;
#(
  parameter int SCK_PER_HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREF-1:0]   rise_i,
  input  src_t              req_src,
  input  logic [HALF_W-1:0] req_half,
  output src_t              act_src,
  output logic              sck_o,
  output logic              ws_o,
  output logic              ws_bound
);
  localparam int BCW = $clog2(SCK_PER_HALF);
  localparam logic [BCW-1:0] BLAST = BCW'(SCK_PER_HALF - 1);

  src_t              act;
  logic [HALF_W-1:0] act_half;
  logic [HALF_W-1:0] ecnt;
  logic [BCW-1:0]    bcnt;
  logic              sck_q, ws_q;
  logic              rise_act, term, differ;

  always_comb begin
    case (act)
      SRC_FS:   rise_act = rise_i[0];
      SRC_MCLK: rise_act = rise_i[1];
      SRC_X22:  rise_act = rise_i[2];
      default:  rise_act = 1'b0;
    endcase
    term     = rise_act && (ecnt == act_half - HALF_W'(1));
    ws_bound = term && sck_q && (bcnt == BLAST);
    differ   = (req_src != act) || (req_half != act_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= SRC_NONE; act_half <= '0; ecnt <= '0; bcnt <= '0;
      sck_q <= 1'b0; ws_q <= 1'b0;
    end else if (act == SRC_NONE) begin
      if (req_src != SRC_NONE) begin
        act      <= req_src;
        act_half <= req_half;
      end
    end else if (ws_bound && differ) begin
      act <= SRC_NONE; act_half <= '0; ecnt <= '0; bcnt <= '0;
      sck_q <= 1'b0; ws_q <= 1'b0;
    end else if (rise_act) begin
      if (term) begin
        ecnt  <= '0;
        sck_q <= ~sck_q;
        if (sck_q) begin
          if (bcnt == BLAST) begin
            bcnt <= '0;
            ws_q <= ~ws_q;
          end else begin
            bcnt <= bcnt + BCW'(1);
          end
        end
      end else begin
        ecnt <= ecnt + HALF_W'(1);
      end
    end
  end

  assign act_src = act;
  assign sck_o   = sck_q;
  assign ws_o    = ws_q;

  // R5: word select moves only together with a falling bit clock
  a_r5_ws_on_sck_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_q != $past(ws_q)) |-> ($past(sck_q) && !sck_q));

  // R3: the bit clock only moves on a reference edge of the active source
  a_r3_sck_needs_ref_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q != $past(sck_q)) |-> $past(rise_act));

  // R7: a running source is only dropped at a slot boundary
  a_r7_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(act) != SRC_NONE) && (act != $past(act))) |-> ($past(ws_bound) && (act == SRC_NONE)));

  // R7: no clock activity while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SRC_NONE) |-> (!sck_q && !ws_q));
endmodule

// File: rtl/aclk_source_gen.sv
module aclk_source_gen
  import aclk_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SCK_PER_HALF = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsclk_in,
  input  logic       mclk_in,
  input  logic       x22_in,
  input  logic [1:0] mode_sel,
  input  logic       mst_src_sel,
  input  logic       ratio384,
  input  logic       mclk24,
  input  logic [1:0] rate_code,
  output logic [1:0] src_sel_o,
  output logic       sck_o,
  output logic       ws_o,
  output logic       config_error_o
);
  logic [NREF-1:0]   rise;
  src_t              req_src, act_src;
  logic [HALF_W-1:0] req_half;
  logic              cfg_bad, ws_bound;

  aclk_edge_sync #(.NREF(NREF), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .ref_in({x22_in, mclk_in, fsclk_in}),
    .rise_o(rise)
  );

  aclk_src_select u_sel (
    .mode_sel(mode_sel), .mst_src_sel(mst_src_sel), .ratio384(ratio384),
    .mclk24(mclk24), .rate_code(rate_code),
    .req_src(req_src), .req_half(req_half), .cfg_bad(cfg_bad)
  );

  aclk_divider #(.SCK_PER_HALF(SCK_PER_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .req_src(req_src), .req_half(req_half),
    .act_src(act_src), .sck_o(sck_o), .ws_o(ws_o), .ws_bound(ws_bound)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) config_error_o <= 1'b0;
    else        config_error_o <= cfg_bad;
  end

  assign src_sel_o = act_src;

  // R6: an illegal setting never lets an idle generator start
  a_r6_no_start_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bad && (act_src == SRC_NONE)) |=> (act_src == SRC_NONE));
endmodule

// File: tb/aclk_source_gen_tb_top.sv
module aclk_source_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsclk_in = 1'b0, mclk_in = 1'b0, x22_in = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic mst_src_sel = 1'b0, ratio384 = 1'b0, mclk24 = 1'b1;
  logic [1:0] rate_code = 2'b00;
  logic [1:0] src_sel_o;
  logic sck_o, ws_o, config_error_o;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  aclk_source_gen dut_i (
    .clk(clk), .rst_n(rst_n), .fsclk_in(fsclk_in), .mclk_in(mclk_in), .x22_in(x22_in),
    .mode_sel(mode_sel), .mst_src_sel(mst_src_sel), .ratio384(ratio384), .mclk24(mclk24),
    .rate_code(rate_code), .src_sel_o(src_sel_o), .sck_o(sck_o), .ws_o(ws_o),
    .config_error_o(config_error_o)
  );

  // free-running references, mutually unlocked
  initial forever begin repeat (2) @(negedge clk); fsclk_in = ~fsclk_in; end
  initial forever begin repeat (2) @(negedge clk); mclk_in  = ~mclk_in;  end
  initial forever begin repeat (3) @(negedge clk); x22_in   = ~x22_in;   end

  // behavioural reference model
  int qf[$] = '{0, 0, 0};
  int qm[$] = '{0, 0, 0};
  int qx[$] = '{0, 0, 0};
  int m_src = 0, m_half = 0, m_e = 0, m_b = 0, m_sck = 0, m_ws = 0, m_err = 0;

  function automatic int divide_of(int s, logic r384, logic [1:0] rate);
    if (s == 1) return r384 ? 6 : 4;
    if (s == 3) return 8;
    if (s == 2) return (rate == 2'b10) ? 12 : 8;
    return 0;
  endfunction

  always @(posedge clk) begin
    int rf, rm, rx, ra, rq, rqh, bad, fin, bnd;
    if (!rst_n) begin
      qf = '{0, 0, 0}; qm = '{0, 0, 0}; qx = '{0, 0, 0};
      m_src = 0; m_half = 0; m_e = 0; m_b = 0; m_sck = 0; m_ws = 0; m_err = 0;
    end else begin
      rf = (qf[1] == 1 && qf[2] == 0);
      rm = (qm[1] == 1 && qm[2] == 0);
      rx = (qx[1] == 1 && qx[2] == 0);
      bad = (mode_sel == 2'b01) ||
            (mode_sel == 2'b00 && !mst_src_sel && (ratio384 || !mclk24 || rate_code == 2'b11));
      if (bad) rq = 0;
      else if (mode_sel != 2'b00 || mst_src_sel) rq = 1;
      else rq = (rate_code == 2'b00) ? 3 : 2;
      rqh = divide_of(rq, ratio384, rate_code) / 2;
      m_err = bad;
      if (m_src == 0) begin
        if (rq != 0) begin m_src = rq; m_half = rqh; end
      end else begin
        ra = (m_src == 1) ? rf : (m_src == 2) ? rm : rx;
        fin = ra && (m_e == m_half - 1);
        bnd = fin && m_sck && (m_b == 31);
        if (bnd && (rq != m_src || rqh != m_half)) begin
          m_src = 0; m_half = 0; m_e = 0; m_b = 0; m_sck = 0; m_ws = 0;
        end else if (ra) begin
          if (fin) begin
            m_e = 0;
            if (m_sck) begin
              if (m_b == 31) begin m_b = 0; m_ws = !m_ws; end
              else m_b++;
            end
            m_sck = !m_sck;
          end else m_e++;
        end
      end
      qf.push_front(int'(fsclk_in)); void'(qf.pop_back());
      qm.push_front(int'(mclk_in));  void'(qm.pop_back());
      qx.push_front(int'(x22_in));   void'(qx.pop_back());
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (src_sel_o !== 2'(m_src) || sck_o !== 1'(m_sck) || ws_o !== 1'(m_ws) ||
          config_error_o !== 1'(m_err)) begin
        failures++;
        $display("FAIL %s t=%0t src/sck/ws/err actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                 tag, $time, src_sel_o, sck_o, ws_o, config_error_o, m_src, m_sck, m_ws, m_err);
      end
    end
  end

  task automatic expect_out(string req, logic [1:0] src, logic err);
    checks++;
    if (src_sel_o !== src || config_error_o !== err) begin
      failures++;
      $display("FAIL %s src/err actual=%0d/%0d expected=%0d/%0d", req, src_sel_o, config_error_o, src, err);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    run(1);
    // R1: reset state
    checks++;
    if (sck_o !== 1'b0 || ws_o !== 1'b0 || src_sel_o !== 2'b00 || config_error_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset sck/ws/src/err actual=%0d/%0d/%0d/%0d expected=0/0/0/0",
               sck_o, ws_o, src_sel_o, config_error_o);
    end
    run(4);
    rst_n = 1'b1;
    tag = "R1"; run(3);
    expect_out("R1", 2'b01, 1'b0);
    tag = "R2_R3_R5"; run(3000);
    expect_out("R2", 2'b01, 1'b0);
    tag = "R3_R7"; ratio384 = 1'b1; run(3500);
    expect_out("R3", 2'b01, 1'b0);
    tag = "R2"; mode_sel = 2'b11; run(1500);
    mode_sel = 2'b00; mst_src_sel = 1'b1; run(1500);
    expect_out("R2", 2'b01, 1'b0);
    tag = "R4_R7"; ratio384 = 1'b0; mclk24 = 1'b1; mst_src_sel = 1'b0; rate_code = 2'b00; run(3500);
    expect_out("R4", 2'b11, 1'b0);
    tag = "R4"; rate_code = 2'b01; run(4000);
    expect_out("R4", 2'b10, 1'b0);
    tag = "R4"; rate_code = 2'b10; run(4500);
    expect_out("R4", 2'b10, 1'b0);
    tag = "R6_R7"; mclk24 = 1'b0; run(4000);
    expect_out("R6", 2'b00, 1'b1);
    tag = "R6"; mclk24 = 1'b1; mode_sel = 2'b01; run(500);
    expect_out("R6", 2'b00, 1'b1);
    mode_sel = 2'b00; rate_code = 2'b11; run(500);
    expect_out("R6", 2'b00, 1'b1);
    rate_code = 2'b01; ratio384 = 1'b1; run(500);
    expect_out("R6", 2'b00, 1'b1);
    tag = "R7"; mode_sel = 2'b10; run(3);
    expect_out("R7", 2'b01, 1'b0);
    run(3000);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired in %s actual=running expected=finished", tag);
      finish_run();
    end
  end
endmodule